// File: doc/BRIEF.md
# Single-Line Interrupt Event Unit

This block holds the interrupt state for one event source. A hardware event pulse sets a pending flag. A mask bit decides whether that flag reaches the interrupt line. Software reaches the block through a simple register port. Through that port it can:

- read the pending flag, raw and masked;
- set the flag on purpose for self-test;
- clear it by writing a one;
- read an index register that names the pending source and retires it in the same access.

A two-bit mode decides how the line behaves:

- Code 0: the line is switched off.
- Code 1: only software retires the flag.
- Code 2: a hardware acknowledge from a neighbouring block may also retire it.

The register port has one write strobe and one read strobe, both sampled at the rising clock edge. Read data is registered. It is valid in the cycle after the read strobe and shows the state as it was before that edge. In every other cycle the read data is zero. Each register is one 32-bit word, and the line uses bit 0 unless a requirement says otherwise.

Top module: `evl_event_unit`

## Requirements
- R1: After reset the raw flag and the mask are 0, the mode is 1 (software clear), irq_out is 0 and reg_rdata is 0.
- R2: An evt_pulse seen at a clock edge sets the raw flag at that edge unless the mode is 0. The masked status read at offset 2 (bit 0) equals the raw flag AND the mask. The raw flag reads at offset 1 (bit 0).
- R3: Writing a word with bit 0 = 1 to offset 3 sets the raw flag in any mode. Writing bit 0 = 0 there changes nothing.
- R4: Writing a word with bit 0 = 1 to offset 4 clears the raw flag whatever the mask is, and in modes 1 and 2. Writing bit 0 = 0 there changes nothing.
- R5: A read of offset 5 returns 1 in bits 4:0 (all other bits 0) when the raw flag and the mask are both 1, and clears the raw flag at that edge. Otherwise it returns 0 and leaves the raw flag unchanged.
- R6: The mode is read and written at offset 6, bits 1:0. In mode 0, evt_pulse is ignored and irq_out stays 0. A mode write is taken only for a word equal to 0, 1 or 2. Any other word leaves the mode unchanged.
- R7: In mode 2, hw_ack high at an edge clears the raw flag. In modes 0 and 1, hw_ack has no effect.
- R8: irq_out equals raw flag AND mask while the mode is not 0. It changes in the same cycle as the state it follows.
- R9: When a set cause and a clear cause meet at the same edge, the raw flag ends up 1. A set cause is an accepted event or a set write. A clear cause is a clear write, a retiring index read or an accepted hw_ack.
- R10: The mask reads and writes at offset 0, bit 0. Reads of offsets 3, 4 and 7 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 1 | Event from the source, one per cycle high |
| hw_ack | input | 1 | Hardware acknowledge (effective in mode 2) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd |
| irq_out | output | 1 | Interrupt request line |

## Verification
The pending flag is the only real state besides the mask and the mode. Any wrong update of it appears on irq_out in the very cycle after the faulty edge, as long as the mask is set and the line is enabled. With the mask clear, the error still shows on the next read of offset 1. A mode that took an illegal code or missed a legal one shows up in two ways: irq_out ignores or follows events against expectation, and offset 6 returns a value other than the one written. A faulty index read shows up in two ways: a wrong code in the cycle after the read, and a flag that survives or vanishes when read back one cycle later.

// File: rtl/evl_pkg.sv
package evl_pkg;

    typedef logic [1:0] mode_t;

    localparam mode_t MODE_OFF   = 2'd0;
    localparam mode_t MODE_SWCLR = 2'd1;
    localparam mode_t MODE_HWACK = 2'd2;

    localparam int unsigned OFS_MASK  = 0;
    localparam int unsigned OFS_RAW   = 1;
    localparam int unsigned OFS_MSTAT = 2;
    localparam int unsigned OFS_SET   = 3;
    localparam int unsigned OFS_CLR   = 4;
    localparam int unsigned OFS_INDEX = 5;
    localparam int unsigned OFS_MODE  = 6;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_RAW,
        SEL_MSTAT,
        SEL_INDEX,
        SEL_MODE
    } rsel_e;

    typedef struct packed {
        logic  wr_mask;
        logic  wr_mode;
        logic  sw_set;
        logic  sw_clr;
        logic  idx_rd;
        rsel_e rsel;
    } strobe_t;

endpackage

// File: rtl/evl_reg_decode.sv
module evl_reg_decode
    import evl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output strobe_t           strb
);

    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(OFS_MSTAT);
    localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(OFS_INDEX);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);

    logic upper_zero;
    logic mode_code_ok;

    always_comb begin
        upper_zero   = (reg_wdata[DATA_W-1:2] == '0);
        mode_code_ok = upper_zero && (reg_wdata[1:0] != 2'b11);

        strb         = '0;
        strb.rsel    = SEL_NONE;
        strb.wr_mask = reg_wr && (reg_addr == A_MASK);
        strb.wr_mode = reg_wr && (reg_addr == A_MODE) && mode_code_ok;
        strb.sw_set  = reg_wr && (reg_addr == A_SET) && reg_wdata[0];
        strb.sw_clr  = reg_wr && (reg_addr == A_CLR) && reg_wdata[0];
        strb.idx_rd  = reg_rd && (reg_addr == A_INDEX);

        if (reg_rd) begin
            unique case (reg_addr)
                A_MASK:  strb.rsel = SEL_MASK;
                A_RAW:   strb.rsel = SEL_RAW;
                A_MSTAT: strb.rsel = SEL_MSTAT;
                A_INDEX: strb.rsel = SEL_INDEX;
                A_MODE:  strb.rsel = SEL_MODE;
                default: strb.rsel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/evl_line_state.sv
module evl_line_state
    import evl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  evt_pulse,
    input  logic  hw_ack,
    input  logic  wr_mask,
    input  logic  wr_mode,
    input  logic  sw_set,
    input  logic  sw_clr,
    input  logic  idx_rd,
    input  logic  wbit0,
    input  mode_t wmode,
    output logic  raw_o,
    output logic  mask_o,
    output mode_t mode_o,
    output logic  irq_o
);

    typedef struct packed {
        logic  raw;
        logic  mask;
        mode_t mode;
    } line_t;

    line_t st_d, st_q;

    logic set_cause;
    logic clr_cause;
    logic pending;

    always_comb begin
        st_d    = st_q;
        pending = st_q.raw && st_q.mask;

        if (wr_mask) st_d.mask = wbit0;
        if (wr_mode) st_d.mode = wmode;

        set_cause = sw_set || (evt_pulse && (st_q.mode != MODE_OFF));
        clr_cause = sw_clr
                 || (idx_rd && pending)
                 || (hw_ack && (st_q.mode == MODE_HWACK));

        if (set_cause)      st_d.raw = 1'b1;
        else if (clr_cause) st_d.raw = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.raw  <= 1'b0;
            st_q.mask <= 1'b0;
            st_q.mode <= MODE_SWCLR;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o  = st_q.raw;
    assign mask_o = st_q.mask;
    assign mode_o = st_q.mode;
    assign irq_o  = st_q.raw && st_q.mask && (st_q.mode != MODE_OFF);

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse && (mode_o != MODE_OFF)) |=> raw_o);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> raw_o);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !sw_set && !evt_pulse) |=> !raw_o);

    p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_OFF) |-> !irq_o);

    p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);

    p_ack_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o != MODE_HWACK) && hw_ack && raw_o && !sw_clr && !idx_rd) |=> raw_o);

endmodule

// File: rtl/evl_read_port.sv
module evl_read_port
    import evl_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 5,
    parameter int LINE_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rsel_e             rsel,
    input  logic              raw,
    input  logic              mask,
    input  mode_t             mode,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [IDX_W-1:0] IDX_CODE = IDX_W'(LINE_IDX);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d      = '0;
        unique case (rsel)
            SEL_MASK:  rd_d.data[0]       = mask;
            SEL_RAW:   rd_d.data[0]       = raw;
            SEL_MSTAT: rd_d.data[0]       = raw && mask;
            SEL_INDEX: if (raw && mask) rd_d.data[IDX_W-1:0] = IDX_CODE;
            SEL_MODE:  rd_d.data[1:0]     = mode;
            default:   rd_d.data          = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q.data;

    p_index_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsel == SEL_INDEX) && !(raw && mask)) |=> (rdata == '0));

    p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == SEL_NONE) |=> (rdata == '0));

endmodule

// File: rtl/evl_event_unit.sv
module evl_event_unit
    import evl_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 5,
    parameter int LINE_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_pulse,
    input  logic              hw_ack,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);

    strobe_t strb;
    logic    raw_w;
    logic    mask_w;
    mode_t   mode_w;

    evl_reg_decode #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_decode (
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .strb     (strb)
    );

    evl_line_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_pulse(evt_pulse),
        .hw_ack   (hw_ack),
        .wr_mask  (strb.wr_mask),
        .wr_mode  (strb.wr_mode),
        .sw_set   (strb.sw_set),
        .sw_clr   (strb.sw_clr),
        .idx_rd   (strb.idx_rd),
        .wbit0    (reg_wdata[0]),
        .wmode    (reg_wdata[1:0]),
        .raw_o    (raw_w),
        .mask_o   (mask_w),
        .mode_o   (mode_w),
        .irq_o    (irq_out)
    );

    evl_read_port #(
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W),
        .LINE_IDX(LINE_IDX)
    ) u_read (
        .clk  (clk),
        .rst_n(rst_n),
        .rsel (strb.rsel),
        .raw  (raw_w),
        .mask (mask_w),
        .mode (mode_w),
        .rdata(reg_rdata)
    );

    p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (mask_w && raw_w));

    p_index_retires_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == ADDR_W'(OFS_INDEX)) && irq_out && !evt_pulse) |=> !raw_w);

endmodule

// File: tb/evl_event_unit_tb_top.sv
module evl_event_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_pulse = 1'b0;
    logic        hw_ack = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evl_event_unit dut_i (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .hw_ack(hw_ack),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                       input logic [31:0] d, input logic e, input logic k);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
        evt_pulse = e; hw_ack = k;
        @(posedge clk); #1;
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        evt_pulse = 0; hw_ack = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1, 0, a, d, 0, 0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        cyc(0, 1, a, '0, 0, 0);
        v = reg_rdata;
    endtask

    initial begin : main
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        check("R1 irq after reset", {31'b0, irq_out}, 0);
        check("R1 rdata after reset", reg_rdata, 0);
        rst_n = 1;
        @(posedge clk); #1;
        rd(1, v);  check("R1 raw reset", v, 0);
        rd(0, v);  check("R1 mask reset", v, 0);
        rd(6, v);  check("R1 mode reset", v, 1);
        check("R10 rdata idle", reg_rdata, v);
        cyc(0, 0, 0, 0, 0, 0);
        check("R10 rdata zero after read", reg_rdata, 0);

        wr(0, 1); rd(0, v); check("R10 mask readback", v, 1);
        wr(0, 0); rd(0, v); check("R10 mask readback 0", v, 0);
        wr(3, 1);
        for (int a = 3; a < 16; a++) begin
            if (a == 5 || a == 6) continue;
            rd(4'(a), v); check("R10 unmapped read zero", v, 0);
        end
        wr(4, 1);

        wr(6, 2); rd(6, v); check("R6 mode 2 taken", v, 2);
        wr(6, 3); rd(6, v); check("R6 code 3 ignored", v, 2);
        wr(6, 32'h5); rd(6, v); check("R6 wide word ignored", v, 2);
        wr(6, 0); rd(6, v); check("R6 mode 0 taken", v, 0);

        for (int m = 0; m < 3; m++) begin
            for (int mk = 0; mk < 2; mk++) begin
                for (int r0 = 0; r0 < 2; r0++) begin
                    for (int act = 0; act < 10; act++) begin
                        logic pend, setv, clrv, exp_raw, exp_irq;
                        string tag;
                        wr(6, 32'(m));
                        wr(0, 32'(mk));
                        if (r0 == 1) wr(3, 1); else wr(4, 1);
                        pend = (r0 == 1) && (mk == 1);
                        setv = (act == 2) ||
                               ((act == 0 || act == 6 || act == 7 || act == 8) && m != 0);
                        clrv = (act == 3) || (act == 6) ||
                               ((act == 5 || act == 7) && pend) ||
                               ((act == 1 || act == 8) && m == 2);
                        exp_raw = setv ? 1'b1 : (clrv ? 1'b0 : 1'(r0));
                        exp_irq = exp_raw && (mk == 1) && (m != 0);
                        case (act)
                            0: begin tag = (m == 0) ? "R6 event ignored" : "R2 event sets"; cyc(0,0,0,0,1,0); end
                            1: begin tag = (m == 2) ? "R7 ack clears" : "R7 ack ignored"; cyc(0,0,0,0,0,1); end
                            2: begin tag = "R3 set write"; cyc(1,0,3,1,0,0); end
                            3: begin tag = "R4 clear write"; cyc(1,0,4,1,0,0); end
                            4: begin tag = "R4 clear zero no effect"; cyc(1,0,4,32'hFFFF_FFFE,0,0); end
                            5: begin tag = "R5 index read"; cyc(0,1,5,0,0,0); end
                            6: begin tag = "R9 event with clear"; cyc(1,0,4,1,1,0); end
                            7: begin tag = "R9 event with index read"; cyc(0,1,5,0,1,0); end
                            8: begin tag = "R9 event with ack"; cyc(0,0,0,0,1,1); end
                            default: begin tag = "R3 set zero no effect"; cyc(1,0,3,32'hFFFF_FFFE,0,0); end
                        endcase
                        if (act == 5 || act == 7)
                            check({tag, " R5 code"}, reg_rdata, pend ? 32'd1 : 32'd0);
                        check({tag, " R8 irq"}, {31'b0, irq_out}, {31'b0, exp_irq});
                        rd(1, v); check({tag, " raw"}, v, {31'b0, exp_raw});
                        rd(2, v); check({tag, " R2 masked"}, v, {31'b0, exp_raw && (mk == 1)});
                    end
                end
            end
        end
        done = 1;
    end

    initial begin : watchdog
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule